// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block is the shifting core of an SPI master. A control register next to it supplies the mode bits, the chip-select choice and two byte counts. It runs one burst of 8-bit frames each time the exchange request is raised while the engine is enabled and in master mode. The burst count sets the total number of frames. The transmit count sets how many of the leading frames take their byte from the transmit FIFO. Every frame after that sends 0x00, so a single burst can write a command and then read a reply.

Received frames go to the receive FIFO. A discard option keeps the bytes that arrive during the transmit phase out of that FIFO. The serial clock advances only on a clock-enable tick from an external divider, and each tick is one half-period. Four chip-select lanes are driven, either automatically around the burst or by a manual level override. At the end of a burst the engine raises a one-cycle completion pulse. The register uses this pulse to clear its exchange bit.

Top module: `spi_burst_engine`

## Requirements
- R1: Out of reset, `busy`, `xfer_done`, `txf_pop` and `rxf_push` are low, `sclk` is low, and every `spi_cs` lane sits at its idle level.
- R2: A burst starts only when `xch_req`, `cfg_enable` and `cfg_master` are all 1 while the engine is idle. If either enable is 0, `xch_req` has no effect.
- R3: Each frame is 8 bits. With `cfg_lsb_first`=0, bit 7 goes first on `mosi` and the first `miso` bit lands in bit 7 of `rxf_data`. With `cfg_lsb_first`=1, bit 0 goes first on `mosi` and the first `miso` bit lands in bit 0 of `rxf_data`.
- R4: `sclk` rests at `cfg_cpol` and changes only on a `tick`. Each frame has exactly 16 transitions. With `cfg_cpha`=0, data is sampled on the leading edge and changed on the trailing edge. With `cfg_cpha`=1, data is changed on the leading edge and sampled on the trailing edge.
- R5: Frames 0 to `tx_cnt`-1 of a burst send bytes popped from the transmit FIFO, in FIFO order. Every later frame sends 0x00.
- R6: With `cfg_discard`=1, frames with index below `tx_cnt` are not pushed to the receive FIFO. Every other frame is pushed exactly once, in order.
- R7: `txf_pop` is never asserted while `txf_empty` is 1. While a transmit byte is owed and the FIFO is empty, `sclk` holds still and the burst waits.
- R8: In automatic mode, only lane `cfg_cs_sel` becomes active. It becomes active at least one tick before the first `sclk` edge and returns to idle one tick after the last edge.
- R9: With `cfg_cs_low`=1, the active level is 0 and the idle level is 1. With `cfg_cs_low`=0, the active level is 1 and the idle level is 0. This applies to all lanes, including the unselected ones.
- R10: With `cfg_cs_manual`=1, lane `cfg_cs_sel` is driven to `cfg_cs_level` whether or not a burst is running, and the other lanes stay at the idle level.
- R11: When the last frame ends, `xfer_done` pulses for one cycle and `busy` falls in that same cycle. No new burst starts until `xch_req` has been seen low.
- R12: A burst with `burst_cnt`=0 gives one `xfer_done` pulse, with no chip-select activity, no `sclk` edges and no `busy` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_master | input | 1 | Master mode select |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | Send and receive bit 0 first |
| cfg_discard | input | 1 | Drop receive bytes during the transmit phase |
| cfg_cs_low | input | 1 | Chip selects are active low |
| cfg_cs_sel | input | $clog2(CS_NUM) | Selected chip-select lane |
| cfg_cs_manual | input | 1 | Manual chip-select control |
| cfg_cs_level | input | 1 | Level driven on the selected lane in manual mode |
| xch_req | input | 1 | Exchange request bit from the control register |
| burst_cnt | input | CNT_W | Frames in the burst |
| tx_cnt | input | CNT_W | Leading frames taken from the transmit FIFO |
| tick | input | 1 | Half-period clock enable |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Transmit FIFO pop |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_data | output | 8 | Receive FIFO write byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | CS_NUM | Chip-select lanes |
| busy | output | 1 | Burst in progress |
| xfer_done | output | 1 | One-cycle burst completion pulse |

## Verification
A wrong byte index or transmit-count comparison shows up in the first frame past the transmit count. The slave then sees a FIFO byte in place of 0x00, or the receive FIFO gets one push too many or too few, and the bound checker flags the push count at the completion pulse. A wrong half-period counter or phase select changes the number of `sclk` transitions or shifts the captured bits, so a corrupted byte appears within the first frame. A broken chip-select decode or stall path shows in the same cycle, as a second active lane or a pop while the FIFO is empty.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int FRAME_W     = 8;
    localparam int BIT_IDX_W   = $clog2(FRAME_W);
    localparam int HALF_CNT    = 2 * FRAME_W;
    localparam int TICK_W      = $clog2(HALF_CNT) + 1;
    localparam int BURST_CNT_W = 24;
    localparam int CS_LANES    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOAD,
        ST_SHIFT,
        ST_BEND,
        ST_TRAIL
    } seq_state_t;

    // mode bits frozen for the length of one burst
    typedef struct packed {
        logic cpha;
        logic lsb_first;
        logic discard;
    } burst_cfg_t;

    // position in the byte of the k-th bit on the wire
    function automatic logic [BIT_IDX_W-1:0] bit_slot(input logic lsb_first,
                                                       input logic [BIT_IDX_W-1:0] k);
        return lsb_first ? k : BIT_IDX_W'(FRAME_W - 1) - k;
    endfunction

    // which wire bit is on mosi after a given number of half-periods
    function automatic logic [BIT_IDX_W-1:0] out_index(input logic cpha,
                                                        input logic [TICK_W-1:0] ticks);
        logic [TICK_W-1:0] t;
        t = cpha ? ((ticks == '0) ? '0 : ticks - 1'b1) : ticks;
        t = t >> 1;
        if (t > TICK_W'(FRAME_W - 1)) t = TICK_W'(FRAME_W - 1);
        return t[BIT_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
    import spi_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              clear,
    input  logic              follow,
    input  logic              idle_level,
    output logic              sclk,
    output logic [TICK_W-1:0] ticks,
    output logic              lead_edge,
    output logic              trail_edge,
    output logic              last_edge
);
    localparam logic [TICK_W-1:0] LAST_HALF = TICK_W'(HALF_CNT - 1);

    logic step;
    assign step       = run && tick;
    assign lead_edge  = step && !ticks[0];
    assign trail_edge = step && ticks[0];
    assign last_edge  = step && (ticks == LAST_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk  <= 1'b0;
            ticks <= '0;
        end else begin
            if (follow)     sclk <= idle_level;
            else if (step)  sclk <= ~sclk;

            if (clear)      ticks <= '0;
            else if (step)  ticks <= ticks + 1'b1;
        end
    end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_burst_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sample,
    input  logic               lsb_first,
    input  logic               din,
    output logic [FRAME_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (sample) begin
            if (lsb_first) data <= {din, data[FRAME_W-1:1]};
            else           data <= {data[FRAME_W-2:0], din};
        end
    end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
    parameter int CS_NUM = 4
) (
    input  logic [$clog2(CS_NUM)-1:0] sel,
    input  logic                      act_low,
    input  logic                      manual,
    input  logic                      man_level,
    input  logic                      auto_on,
    output logic [CS_NUM-1:0]         cs
);
    localparam int IDX_W = $clog2(CS_NUM);

    logic sel_level;
    assign sel_level = manual ? man_level : (auto_on ? ~act_low : act_low);

    for (genvar i = 0; i < CS_NUM; i++) begin : g_lane
        assign cs[i] = (sel == IDX_W'(i)) ? sel_level : act_low;
    end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int CNT_W  = BURST_CNT_W,
    parameter int CS_NUM = CS_LANES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_enable,
    input  logic                      cfg_master,
    input  logic                      cfg_cpol,
    input  logic                      cfg_cpha,
    input  logic                      cfg_lsb_first,
    input  logic                      cfg_discard,
    input  logic                      cfg_cs_low,
    input  logic [$clog2(CS_NUM)-1:0] cfg_cs_sel,
    input  logic                      cfg_cs_manual,
    input  logic                      cfg_cs_level,
    input  logic                      xch_req,
    input  logic [CNT_W-1:0]          burst_cnt,
    input  logic [CNT_W-1:0]          tx_cnt,
    input  logic                      tick,
    input  logic                      txf_empty,
    input  logic [FRAME_W-1:0]        txf_data,
    output logic                      txf_pop,
    output logic                      rxf_push,
    output logic [FRAME_W-1:0]        rxf_data,
    output logic                      sclk,
    output logic                      mosi,
    input  logic                      miso,
    output logic [CS_NUM-1:0]         spi_cs,
    output logic                      busy,
    output logic                      xfer_done
);
    seq_state_t          state;
    burst_cfg_t          cfg;
    logic [CNT_W-1:0]    byte_idx;
    logic [CNT_W-1:0]    burst_r;
    logic [CNT_W-1:0]    txcnt_r;
    logic [FRAME_W-1:0]  tx_byte;
    logic                cs_on;
    logic                done_r;
    logic                hold_off;

    logic [TICK_W-1:0]   ticks;
    logic                lead_edge, trail_edge, last_edge;
    logic                owe_tx;
    logic                start;

    assign owe_tx = byte_idx < txcnt_r;
    assign start  = (state == ST_IDLE) && xch_req && cfg_enable && cfg_master && !hold_off;

    assign txf_pop   = (state == ST_LOAD) && owe_tx && !txf_empty;
    assign rxf_push  = (state == ST_BEND) && !(cfg.discard && owe_tx);
    assign busy      = (state != ST_IDLE);
    assign xfer_done = done_r;
    assign mosi      = tx_byte[bit_slot(cfg.lsb_first, out_index(cfg.cpha, ticks))];

    spi_clk_gen u_clk (
        .clk        (clk),
        .rst        (rst),
        .run        (state == ST_SHIFT),
        .tick       (tick),
        .clear      (state == ST_LOAD),
        .follow     (state == ST_IDLE),
        .idle_level (cfg_cpol),
        .sclk       (sclk),
        .ticks      (ticks),
        .lead_edge  (lead_edge),
        .trail_edge (trail_edge),
        .last_edge  (last_edge)
    );

    spi_rx_shift u_rx (
        .clk       (clk),
        .rst       (rst),
        .sample    (cfg.cpha ? trail_edge : lead_edge),
        .lsb_first (cfg.lsb_first),
        .din       (miso),
        .data      (rxf_data)
    );

    spi_cs_drive #(.CS_NUM(CS_NUM)) u_cs (
        .sel       (cfg_cs_sel),
        .act_low   (cfg_cs_low),
        .manual    (cfg_cs_manual),
        .man_level (cfg_cs_level),
        .auto_on   (cs_on),
        .cs        (spi_cs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg      <= '0;
            byte_idx <= '0;
            burst_r  <= '0;
            txcnt_r  <= '0;
            tx_byte  <= '0;
            cs_on    <= 1'b0;
            done_r   <= 1'b0;
            hold_off <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (!xch_req) hold_off <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg.cpha      <= cfg_cpha;
                        cfg.lsb_first <= cfg_lsb_first;
                        cfg.discard   <= cfg_discard;
                        burst_r       <= burst_cnt;
                        txcnt_r       <= tx_cnt;
                        byte_idx      <= '0;
                        if (burst_cnt == '0) begin
                            done_r   <= 1'b1;
                            hold_off <= 1'b1;
                        end else begin
                            cs_on <= 1'b1;
                            state <= ST_LEAD;
                        end
                    end
                end
                ST_LEAD: begin
                    if (tick) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (!owe_tx) begin
                        tx_byte <= '0;
                        state   <= ST_SHIFT;
                    end else if (!txf_empty) begin
                        tx_byte <= txf_data;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_edge) state <= ST_BEND;
                end
                ST_BEND: begin
                    byte_idx <= byte_idx + 1'b1;
                    state    <= (byte_idx + 1'b1 == burst_r) ? ST_TRAIL : ST_LOAD;
                end
                ST_TRAIL: begin
                    if (tick) begin
                        cs_on    <= 1'b0;
                        done_r   <= 1'b1;
                        hold_off <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

module spi_burst_engine_chk #(
    parameter int CNT_W  = 24,
    parameter int CS_NUM = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              xfer_done,
    input logic              txf_pop,
    input logic              txf_empty,
    input logic              rxf_push,
    input logic [CS_NUM-1:0] spi_cs,
    input logic              sclk,
    input logic              tick,
    input logic              cfg_cs_low,
    input logic              cfg_cs_manual,
    input logic              cfg_discard,
    input logic [CNT_W-1:0]  burst_cnt,
    input logic [CNT_W-1:0]  tx_cnt
);
    logic             busy_q;
    logic [CNT_W-1:0] push_cnt;
    logic [CNT_W-1:0] push_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            push_cnt <= '0;
            push_exp <= '0;
        end else begin
            busy_q <= busy;
            if (busy && !busy_q) begin
                push_cnt <= '0;
                if (!cfg_discard)          push_exp <= burst_cnt;
                else if (tx_cnt >= burst_cnt) push_exp <= '0;
                else                        push_exp <= burst_cnt - tx_cnt;
            end else if (rxf_push) begin
                push_cnt <= push_cnt + 1'b1;
            end
        end
    end

    // R7
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        txf_pop |-> !txf_empty);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !busy);

    // R11
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> xfer_done);

    // R9
    idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_cs_manual) |-> (spi_cs == {CS_NUM{cfg_cs_low}}));

    // R8
    one_lane_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(spi_cs ^ {CS_NUM{cfg_cs_low}}) <= 1);

    // R4
    sclk_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(tick)) |-> $stable(sclk));

    // R6
    push_count_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && busy_q) |-> (push_cnt == push_exp));
endmodule

bind spi_burst_engine spi_burst_engine_chk #(.CNT_W(CNT_W), .CS_NUM(CS_NUM)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .xfer_done     (xfer_done),
    .txf_pop       (txf_pop),
    .txf_empty     (txf_empty),
    .rxf_push      (rxf_push),
    .spi_cs        (spi_cs),
    .sclk          (sclk),
    .tick          (tick),
    .cfg_cs_low    (cfg_cs_low),
    .cfg_cs_manual (cfg_cs_manual),
    .cfg_discard   (cfg_discard),
    .burst_cnt     (burst_cnt),
    .tx_cnt        (tx_cnt)
);

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic c_en = 1'b1, c_mst = 1'b1, c_cpol = 1'b0, c_cpha = 1'b0, c_lsb = 1'b0;
    logic c_disc = 1'b0, c_cslow = 1'b1, c_man = 1'b0, c_lvl = 1'b0, c_xch = 1'b0;
    logic [1:0]  c_sel = 2'd0;
    logic [23:0] c_burst = '0, c_tx = '0;

    logic tick = 1'b0;
    int   tdiv = 1;
    int   tcnt = 0;

    logic [7:0] tmem [0:255];
    int   twr = 0, trd = 0;
    logic txf_empty, txf_pop;
    logic [7:0] txf_data;
    assign txf_empty = (trd == twr);
    assign txf_data  = tmem[trd[7:0]];

    logic [7:0] rmem [0:255];
    int   rcnt = 0;
    logic rxf_push;
    logic [7:0] rxf_data;

    logic sclk, mosi, miso, busy, xfer_done;
    logic [3:0] spi_cs;
    int ndone = 0, nbusy = 0;
    int checks = 0, fails = 0;

    spi_burst_engine u_spi_burst_engine (
        .clk(clk), .rst(rst),
        .cfg_enable(c_en), .cfg_master(c_mst), .cfg_cpol(c_cpol), .cfg_cpha(c_cpha),
        .cfg_lsb_first(c_lsb), .cfg_discard(c_disc), .cfg_cs_low(c_cslow),
        .cfg_cs_sel(c_sel), .cfg_cs_manual(c_man), .cfg_cs_level(c_lvl),
        .xch_req(c_xch), .burst_cnt(c_burst), .tx_cnt(c_tx), .tick(tick),
        .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
        .rxf_push(rxf_push), .rxf_data(rxf_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .spi_cs(spi_cs),
        .busy(busy), .xfer_done(xfer_done)
    );

    always @(posedge clk) begin
        if (tcnt >= tdiv - 1) begin tcnt <= 0; tick <= 1'b1; end
        else begin tcnt <= tcnt + 1; tick <= 1'b0; end
        if (txf_pop) trd <= trd + 1;
        if (rxf_push) begin rmem[rcnt[7:0]] <= rxf_data; rcnt <= rcnt + 1; end
        if (xfer_done) ndone <= ndone + 1;
        if (busy) nbusy <= nbusy + 1;
    end

    function automatic logic [7:0] tx_pat(input int i);
        return 8'(8'h3C + i * 71);
    endfunction
    function automatic logic [7:0] resp(input int i);
        return 8'(8'hA5 ^ (i * 29));
    endfunction
    function automatic logic obit(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    // slave model on the serial side
    logic miso_r = 1'b0;
    assign miso = miso_r;
    logic s_act, s_act_q = 1'b0, sclk_q = 1'b0, s_first_ok = 1'b0;
    int   s_idx = 0, s_bit = 0, s_edges = 0;
    logic [7:0] s_cap = '0;
    logic [7:0] s_got [0:63];
    logic [3:0] cs_seen = '0;

    always @(negedge clk) begin
        s_act = (spi_cs[c_sel] != c_cslow);
        if (s_act && !s_act_q) begin
            s_idx = 0; s_bit = 0; s_edges = 0; s_cap = '0;
            s_first_ok = (sclk == c_cpol);
            miso_r = obit(resp(0), 0, c_lsb);
        end else if (s_act && sclk != sclk_q) begin
            s_edges++;
            if (sclk_q == c_cpol) begin
                if (!c_cpha) s_cap = c_lsb ? {mosi, s_cap[7:1]} : {s_cap[6:0], mosi};
                else miso_r = obit(resp(s_idx), s_bit, c_lsb);
            end else begin
                if (c_cpha) s_cap = c_lsb ? {mosi, s_cap[7:1]} : {s_cap[6:0], mosi};
                s_bit++;
                if (s_bit == 8) begin
                    if (s_idx < 64) s_got[s_idx] = s_cap;
                    s_idx++;
                    s_bit = 0;
                end
                if (!c_cpha) miso_r = obit(resp(s_idx), s_bit, c_lsb);
            end
        end
        s_act_q = s_act;
        sclk_q  = sclk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        cs_seen = {4{c_cslow}};
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (busy && spi_cs != {4{c_cslow}} && cs_seen == {4{c_cslow}}) cs_seen = spi_cs;
            if (xfer_done) begin seen = 1; break; end
        end
    endtask

    task automatic run_burst(input int nb, input int ntx, input logic cpol, input logic cpha,
                             input logic lsb, input logic disc, input int sel,
                             input logic cslow, input int div, input int hold);
        int rbase, dbase, bbase, nexp, j;
        bit seen;
        @(negedge clk);
        c_cpol = cpol; c_cpha = cpha; c_lsb = lsb; c_disc = disc;
        c_sel = 2'(sel); c_cslow = cslow; c_man = 1'b0; tdiv = div;
        c_burst = 24'(nb); c_tx = 24'(ntx);
        for (int i = 0; i < ntx && i < nb; i++) begin tmem[twr[7:0]] = tx_pat(i); twr++; end
        repeat (3) @(negedge clk);
        rbase = rcnt; dbase = ndone; bbase = nbusy;
        c_xch = 1'b1;
        wait_done(seen);
        chk(seen, "R11", "completion pulse seen", seen, 1);
        repeat (hold) @(negedge clk);
        c_xch = 1'b0;
        repeat (3) @(negedge clk);
        chk(ndone - dbase == 1, "R11", "one pulse per request", ndone - dbase, 1);
        chk(!busy, "R11", "idle after completion", busy, 0);
        chk(spi_cs == {4{cslow}}, "R9", "lanes idle after burst", spi_cs, {4{cslow}});
        chk(sclk == cpol, "R4", "sclk rests at polarity", sclk, cpol);
        if (nb == 0) begin
            chk(nbusy == bbase, "R12", "no busy cycle", nbusy - bbase, 0);
            chk(rcnt == rbase, "R12", "no pushes", rcnt - rbase, 0);
        end else begin
            chk(s_idx == nb, "R3", "frames seen by slave", s_idx, nb);
            chk(s_edges == 16 * nb, "R4", "sclk transitions", s_edges, 16 * nb);
            chk(s_first_ok, "R8", "lane active before first edge", s_first_ok, 1);
            chk(cs_seen == ({4{cslow}} ^ (4'b1 << sel)), "R8", "single selected lane",
                cs_seen, {4{cslow}} ^ (4'b1 << sel));
            for (int i = 0; i < nb && i < 64; i++) begin
                logic [7:0] e;
                e = (i < ntx) ? tx_pat(i) : 8'h00;
                chk(s_got[i] == e, "R5", $sformatf("mosi byte %0d", i), s_got[i], e);
            end
            nexp = 0;
            for (int i = 0; i < nb; i++) if (!(disc && i < ntx)) nexp++;
            chk(rcnt - rbase == nexp, "R6", "receive pushes", rcnt - rbase, nexp);
            j = rbase;
            for (int i = 0; i < nb; i++) begin
                if (!(disc && i < ntx) && j < rcnt) begin
                    chk(rmem[j[7:0]] == resp(i), "R3", $sformatf("rx byte %0d", i),
                        rmem[j[7:0]], resp(i));
                    j++;
                end
            end
        end
        if (hold > 0) chk(nbusy == bbase + (nbusy - bbase) && ndone - dbase == 1, "R11",
                          "no restart while request held", ndone - dbase, 1);
    endtask

    task automatic t_reset;
        chk(!busy && !xfer_done, "R1", "busy/done after reset", {busy, xfer_done}, 0);
        chk(!txf_pop && !rxf_push, "R1", "fifo strobes after reset", {txf_pop, rxf_push}, 0);
        chk(spi_cs == 4'hF, "R1", "lanes after reset", spi_cs, 4'hF);
        chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    endtask

    task automatic t_no_enable;
        int d0, b0;
        @(negedge clk);
        d0 = ndone; b0 = nbusy;
        c_en = 1'b0; c_xch = 1'b1;
        repeat (30) @(negedge clk);
        chk(nbusy == b0 && ndone == d0, "R2", "no burst with enable low", nbusy - b0, 0);
        c_xch = 1'b0; c_en = 1'b1; c_mst = 1'b0;
        @(negedge clk); c_xch = 1'b1;
        repeat (30) @(negedge clk);
        chk(nbusy == b0 && ndone == d0, "R2", "no burst with master low", nbusy - b0, 0);
        c_xch = 1'b0; c_mst = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_stall;
        int rbase;
        bit seen;
        @(negedge clk);
        c_cpol = 0; c_cpha = 0; c_lsb = 0; c_disc = 0; c_sel = 0; c_cslow = 1; tdiv = 1;
        c_burst = 24'd2; c_tx = 24'd2;
        tmem[twr[7:0]] = tx_pat(0); twr++;
        rbase = rcnt;
        c_xch = 1'b1;
        for (int k = 0; k < 2000 && rcnt == rbase; k++) @(negedge clk);
        repeat (50) @(negedge clk);
        chk(busy, "R7", "waiting for owed byte", busy, 1);
        chk(sclk == 1'b0, "R7", "sclk held while stalled", sclk, 0);
        chk(s_idx == 1 && rcnt == rbase + 1, "R7", "one frame before stall", s_idx, 1);
        tmem[twr[7:0]] = tx_pat(1); twr++;
        wait_done(seen);
        c_xch = 1'b0;
        repeat (3) @(negedge clk);
        chk(seen && s_got[1] == tx_pat(1), "R7", "late byte sent", s_got[1], tx_pat(1));
    endtask

    task automatic t_manual;
        @(negedge clk);
        c_cslow = 1; c_sel = 2'd1; c_man = 1; c_lvl = 0;
        @(negedge clk);
        chk(spi_cs == 4'b1101, "R10", "manual low on lane 1", spi_cs, 4'b1101);
        c_lvl = 1;
        @(negedge clk);
        chk(spi_cs == 4'b1111, "R10", "manual high on lane 1", spi_cs, 4'b1111);
        c_cslow = 0;
        @(negedge clk);
        chk(spi_cs == 4'b0010, "R10", "manual high, active-high lanes", spi_cs, 4'b0010);
        c_lvl = 0;
        @(negedge clk);
        chk(spi_cs == 4'b0000, "R9", "active-high idle lanes", spi_cs, 4'b0000);
        c_man = 0; c_cslow = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_enable();
        run_burst(3, 3, 0, 0, 0, 0, 0, 1, 1, 0);
        run_burst(4, 4, 1, 1, 1, 0, 3, 0, 3, 0);
        run_burst(5, 2, 0, 1, 0, 1, 2, 1, 2, 0);
        run_burst(4, 1, 1, 0, 1, 0, 1, 1, 1, 0);
        run_burst(2, 0, 0, 0, 0, 1, 0, 1, 2, 30);
        run_burst(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        t_stall();
        t_manual();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule